// File: doc/BRIEF.md
# Two-Address Writeback and Program Counter Unit

This block sequences a small 8-bit machine whose instructions name two memory addresses. Each 32-bit instruction word holds a 16-bit control part, an A field and a B field. In one step the unit fetches the word at the program counter, reads the data at address A (or takes the A field itself as a constant), reads the data at address B, and presents both operands to an external combinational ALU. The ALU result goes back to memory through a single write port, aimed at either the A address or the B address. The same step sets the next program counter and the carry flag.

A jump always takes its target from the B field. This lets self-modifying code retarget a jump or a store by rewriting only the B byte. Results that land on the A address, such as a counting loop variable or a value fetched through a patched pointer, use the same write port through an address multiplexer. Subroutine calls store the return address into the data byte of the word at address A and then jump to B. A halt instruction parks the unit until a step or run input arrives. The 256-word memory sits inside the unit. A load port writes whole words into it, and a peek port reads any word back.

Top module: `twoaddr_step_unit`

## Requirements
- R1: During and right after reset the program counter is 0, the carry flag is 0 and the unit is halted.
- R2: The A operand sent to the ALU is the A field itself when control bit 13 (immediate) is set. Otherwise it is the low 8 bits of the word at address A.
- R3: The B operand sent to the ALU is zero when control bit 5 (B mask) is set. Otherwise it is the low 8 bits of the word at address B. Storing an immediate through the mask writes that constant unchanged.
- R4: On an executed step, control bit 15 writes the ALU result to address A. Without bit 15, bit 14 writes it to address B. When both are set, only A is written. A writeback replaces only the low 8 bits of the target word; the upper 24 bits keep their value.
- R5: The jump condition is control bits 10:8: 0 never, 1 always, 2 ALU carry-out set, 3 ALU carry-out clear, 4 ALU result zero, 5 ALU result nonzero, 6 carry flag set, 7 carry flag clear. A taken jump loads the B field into the PC. Otherwise the PC advances by one and wraps from 255 to 0.
- R6: Carry mode is control bits 7:6: 0 keeps the flag, 1 takes the ALU carry-out, 2 clears it, 3 sets it.
- R7: Control bit 11 (link) writes PC+1 into the low byte at address A, loads the B field into the PC and clears carry. It overrides the write bits, the jump condition and the carry mode.
- R8: Control bit 12 (halt) finishes its step normally with the carry flag unchanged, whatever the carry mode says, and then leaves the unit halted. A halted unit changes neither PC nor carry until step or run is high.
- R9: While halted, a cycle with step or run high executes the instruction at the PC and clears the halt state, unless that instruction halts again.
- R10: A cycle with the load strobe high writes the full 32-bit word and executes no instruction.
- R11: The peek port returns the full word at the peek address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Execute one instruction while halted |
| run | input | 1 | Leave halt and keep executing |
| ld_we | input | 1 | Load strobe for a full memory word |
| ld_addr | input | 8 | Load address |
| ld_word | input | 32 | Load data |
| peek_addr | input | 8 | Read-back address |
| peek_word | output | 32 | Word at the read-back address |
| alu_op | output | 5 | Operation code for the external ALU |
| alu_a | output | 8 | A operand |
| alu_b | output | 8 | B operand |
| alu_cin | output | 1 | Current carry flag |
| alu_y | input | 8 | ALU result |
| alu_cout | input | 1 | ALU carry-out |
| pc | output | 8 | Program counter |
| carry | output | 1 | Carry flag |
| halted | output | 1 | Unit is waiting for step or run |

## Verification
The hardest state to reach is a step where two control effects collide: a call word that also has the B-write bit, a set carry mode and a jump condition, or a halt word whose carry mode would clear a set flag. Only a running program that arrives at such a word with known memory and carry exposes which effect wins. The stimulus loads a program that first counts a byte from 0xFC to overflow with an increment-and-jump loop, and a load is injected during that loop to stall it. The program then calls through the link path, sets carry and halts on it. A single step pulse restarts it into a word carrying both write bits and a wrapping jump to the last address. A behavioural model tracks every cycle and then compares all 256 words.

// File: rtl/tas_pkg.sv
// Shared encodings for the two-address step unit.
// Assumes a 16-bit control part whose packed field order is the bit layout.
package tas_pkg;

    localparam int CTRL_W = 16;
    localparam int OP_W   = 5;

    typedef enum logic [2:0] {
        JC_NEVER  = 3'd0,
        JC_ALWAYS = 3'd1,
        JC_COUT   = 3'd2,
        JC_NCOUT  = 3'd3,
        JC_ZERO   = 3'd4,
        JC_NZERO  = 3'd5,
        JC_CSET   = 3'd6,
        JC_CCLR   = 3'd7
    } jcond_e;

    typedef enum logic [1:0] {
        CM_KEEP  = 2'd0,
        CM_ALU   = 2'd1,
        CM_CLEAR = 2'd2,
        CM_SET   = 2'd3
    } cmode_e;

    // Bit 15 first: wr_a, wr_b, imm, halt, link, jc[10:8], cm[7:6], bmask, op[4:0]
    typedef struct packed {
        logic            wr_a;
        logic            wr_b;
        logic            imm;
        logic            halt;
        logic            link;
        jcond_e          jc;
        cmode_e          cm;
        logic            bmask;
        logic [OP_W-1:0] op;
    } ctrl_t;

endpackage

// File: rtl/tas_store.sv
// Word memory of the unit: one write port shared by the loader and writeback,
// with asynchronous reads for fetch, both operands and peek.
// Assumes the loader is never active in the same cycle as an executed step
// (the sequencer stalls on load). Contents are not reset.
module tas_store #(
    parameter int AW     = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              wb_en,
    input  logic [AW-1:0]     wb_addr,
    input  logic [AW-1:0]     wb_data,
    input  logic [AW-1:0]     fetch_addr,
    output logic [WORD_W-1:0] fetch_word,
    input  logic [AW-1:0]     rda_addr,
    output logic [AW-1:0]     rda_data,
    input  logic [AW-1:0]     rdb_addr,
    output logic [AW-1:0]     rdb_data,
    input  logic [AW-1:0]     peek_addr,
    output logic [WORD_W-1:0] peek_word
);

    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] words [DEPTH];

    // Single write port: full-word load wins, else byte writeback.
    always_ff @(posedge clk) begin
        if (ld_we) begin
            words[ld_addr] <= ld_word;
        end else if (wb_en) begin
            words[wb_addr][AW-1:0] <= wb_data;
        end
    end

    // Combinational read ports.
    assign fetch_word = words[fetch_addr];
    assign rda_data   = words[rda_addr][AW-1:0];
    assign rdb_data   = words[rdb_addr][AW-1:0];
    assign peek_word  = words[peek_addr];

endmodule

// File: rtl/tas_operand.sv
// Splits a fetched word into control, A and B fields and forms the two
// ALU operands (immediate select on A, zero mask on B).
// Assumes WORD_W = CTRL_W + 2*AW.
module tas_operand
    import tas_pkg::*;
#(
    parameter int AW     = 8,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] instr_word,
    input  logic [AW-1:0]     rda_data,
    input  logic [AW-1:0]     rdb_data,
    output ctrl_t             ctrl,
    output logic [AW-1:0]     a_fld,
    output logic [AW-1:0]     b_fld,
    output logic [AW-1:0]     opnd_a,
    output logic [AW-1:0]     opnd_b
);

    // Field split of the instruction word.
    always_comb begin
        ctrl  = ctrl_t'(instr_word[WORD_W-1 -: CTRL_W]);
        a_fld = instr_word[2*AW-1:AW];
        b_fld = instr_word[AW-1:0];
    end

    // Operand selection for the ALU.
    always_comb begin
        opnd_a = ctrl.imm   ? a_fld : rda_data;
        opnd_b = ctrl.bmask ? '0    : rdb_data;
    end

endmodule

// File: rtl/tas_seq.sv
// Sequencer state: program counter, carry flag and halt state.
// Decides whether a step executes, evaluates the jump condition and updates
// PC and carry. Assumes a combinational ALU feeding alu_y/alu_cout this cycle.
module tas_seq
    import tas_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          run,
    input  logic          ld_we,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] b_fld,
    input  logic [AW-1:0] alu_y,
    input  logic          alu_cout,
    output logic          exec,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] pc_inc,
    output logic          carry_q,
    output logic          halted_q
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic taken;

    // A step executes unless a load stalls it or the unit is parked.
    assign exec   = !ld_we && (!halted_q || step || run);
    assign pc_inc = pc_q + ONE;

    // Jump condition decode.
    always_comb begin
        case (ctrl.jc)
            JC_NEVER:  taken = 1'b0;
            JC_ALWAYS: taken = 1'b1;
            JC_COUT:   taken = alu_cout;
            JC_NCOUT:  taken = !alu_cout;
            JC_ZERO:   taken = (alu_y == '0);
            JC_NZERO:  taken = (alu_y != '0);
            JC_CSET:   taken = carry_q;
            JC_CCLR:   taken = !carry_q;
            default:   taken = 1'b0;
        endcase
    end

    // PC, carry and halt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            carry_q  <= 1'b0;
            halted_q <= 1'b1;
        end else if (exec) begin
            halted_q <= ctrl.halt;
            if (ctrl.link) begin
                pc_q    <= b_fld;
                carry_q <= 1'b0;
            end else begin
                pc_q <= taken ? b_fld : pc_inc;
                if (!ctrl.halt) begin
                    case (ctrl.cm)
                        CM_ALU:   carry_q <= alu_cout;
                        CM_CLEAR: carry_q <= 1'b0;
                        CM_SET:   carry_q <= 1'b1;
                        default:  carry_q <= carry_q;
                    endcase
                end
            end
        end
    end

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> ($stable(pc_q) && $stable(carry_q)));

    assert_halt_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ctrl.halt) |=> halted_q);

    assert_halt_keeps_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ctrl.halt && !ctrl.link) |=> $stable(carry_q));

    assert_link_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ctrl.link) |=> (!carry_q && pc_q == $past(b_fld)));

    assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ctrl.link && taken) |=> (pc_q == $past(b_fld)));

    assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ctrl.link && !taken) |=> (pc_q == $past(pc_q) + ONE));

    assert_keep_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ctrl.link && ctrl.cm == CM_KEEP) |=> $stable(carry_q));

    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !ld_we && (step || run) && !ctrl.halt) |=> !halted_q);

endmodule

// File: rtl/twoaddr_step_unit.sv
// Top of the two-address step unit. Joins memory, operand forming and the
// sequencer, and owns the single writeback multiplexer: link or write-A
// targets the A address, otherwise write-B targets the B address.
// Assumes data width equals address width (A field doubles as immediate,
// return address fits a data byte) and an external combinational ALU.
module twoaddr_step_unit
    import tas_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     run,
    input  logic                     ld_we,
    input  logic [AW-1:0]            ld_addr,
    input  logic [CTRL_W+2*AW-1:0]   ld_word,
    input  logic [AW-1:0]            peek_addr,
    output logic [CTRL_W+2*AW-1:0]   peek_word,
    output logic [OP_W-1:0]          alu_op,
    output logic [AW-1:0]            alu_a,
    output logic [AW-1:0]            alu_b,
    output logic                     alu_cin,
    input  logic [AW-1:0]            alu_y,
    input  logic                     alu_cout,
    output logic [AW-1:0]            pc,
    output logic                     carry,
    output logic                     halted
);

    localparam int WORD_W = CTRL_W + 2 * AW;

    logic [WORD_W-1:0] instr_word;
    logic [AW-1:0]     rda_data, rdb_data;
    ctrl_t             ctrl;
    logic [AW-1:0]     a_fld, b_fld;
    logic              exec;
    logic [AW-1:0]     pc_q, pc_inc;
    logic              carry_q, halted_q;
    logic              to_a;
    logic              wb_en;
    logic [AW-1:0]     wb_addr, wb_data;

    // Writeback multiplexer onto the single memory write port.
    always_comb begin
        to_a    = ctrl.link || ctrl.wr_a;
        wb_en   = exec && (to_a || ctrl.wr_b);
        wb_addr = to_a ? a_fld : b_fld;
        wb_data = ctrl.link ? pc_inc : alu_y;
    end

    tas_store #(.AW(AW), .WORD_W(WORD_W)) u_store (
        .clk        (clk),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_word    (ld_word),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .fetch_addr (pc_q),
        .fetch_word (instr_word),
        .rda_addr   (a_fld),
        .rda_data   (rda_data),
        .rdb_addr   (b_fld),
        .rdb_data   (rdb_data),
        .peek_addr  (peek_addr),
        .peek_word  (peek_word)
    );

    tas_operand #(.AW(AW), .WORD_W(WORD_W)) u_operand (
        .instr_word (instr_word),
        .rda_data   (rda_data),
        .rdb_data   (rdb_data),
        .ctrl       (ctrl),
        .a_fld      (a_fld),
        .b_fld      (b_fld),
        .opnd_a     (alu_a),
        .opnd_b     (alu_b)
    );

    tas_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .run      (run),
        .ld_we    (ld_we),
        .ctrl     (ctrl),
        .b_fld    (b_fld),
        .alu_y    (alu_y),
        .alu_cout (alu_cout),
        .exec     (exec),
        .pc_q     (pc_q),
        .pc_inc   (pc_inc),
        .carry_q  (carry_q),
        .halted_q (halted_q)
    );

    assign alu_op  = ctrl.op;
    assign alu_cin = carry_q;
    assign pc      = pc_q;
    assign carry   = carry_q;
    assign halted  = halted_q;

    assert_load_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> ($stable(pc_q) && $stable(halted_q)));

endmodule

// File: tb/twoaddr_step_unit_tb.sv
module twoaddr_step_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, run = 1'b0, ld_we = 1'b0;
    logic [7:0]  ld_addr = '0, peek_addr = '0;
    logic [31:0] ld_word = '0;
    logic [31:0] peek_word;
    logic [4:0]  alu_op;
    logic [7:0]  alu_a, alu_b, alu_y, pc;
    logic        alu_cin, alu_cout, carry, halted;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [31:0] m_mem [256];
    logic [7:0]  m_pc = '0;
    logic        m_carry = 1'b0;
    logic        m_halted = 1'b1;
    bit          mem_ready = 1'b0;

    always #10 clk = ~clk;

    twoaddr_step_unit u_dut (
        .clk(clk), .rst_n(rst_n), .step(step), .run(run),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_word(ld_word),
        .peek_addr(peek_addr), .peek_word(peek_word),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_cin(alu_cin),
        .alu_y(alu_y), .alu_cout(alu_cout),
        .pc(pc), .carry(carry), .halted(halted)
    );

    // Bench ALU: 0 add, 1 add+carry, 2 b-a, 3 and, 4 a+1
    function automatic logic [8:0] alu_fn(logic [4:0] op, logic [7:0] a, logic [7:0] b, logic cin);
        case (op)
            5'd0: return {1'b0, a} + {1'b0, b};
            5'd1: return {1'b0, a} + {1'b0, b} + {8'd0, cin};
            5'd2: return {1'b0, b} + {1'b0, ~a} + 9'd1;
            5'd3: return {1'b0, a & b};
            5'd4: return {1'b0, a} + 9'd1;
            default: return 9'd0;
        endcase
    endfunction

    always_comb {alu_cout, alu_y} = alu_fn(alu_op, alu_a, alu_b, alu_cin);

    function automatic logic [15:0] cw(bit wa, bit wb, bit im, bit hl, bit lk,
                                       logic [2:0] jc, logic [1:0] cm, bit bz, logic [4:0] op);
        return {wa, wb, im, hl, lk, jc, cm, bz, op};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: inputs are already driven at the preceding falling edge.
    task automatic tick();
        logic [31:0] w;
        logic [15:0] c;
        logic [7:0]  fa, fb, oa, ob;
        logic [8:0]  r;
        logic        ex, tk;
        w  = m_mem[m_pc];
        c  = w[31:16];
        fa = w[15:8];
        fb = w[7:0];
        oa = c[13] ? fa : m_mem[fa][7:0];
        ob = c[5] ? 8'd0 : m_mem[fb][7:0];
        r  = alu_fn(c[4:0], oa, ob, m_carry);
        ex = !ld_we && (!m_halted || step || run);
        case (c[10:8])
            3'd0: tk = 1'b0;
            3'd1: tk = 1'b1;
            3'd2: tk = r[8];
            3'd3: tk = !r[8];
            3'd4: tk = (r[7:0] == 8'd0);
            3'd5: tk = (r[7:0] != 8'd0);
            3'd6: tk = m_carry;
            default: tk = !m_carry;
        endcase
        #1;
        if (mem_ready) begin
            chk("R2 alu_a", {24'd0, alu_a}, {24'd0, oa});
            chk("R3 alu_b", {24'd0, alu_b}, {24'd0, ob});
        end
        @(posedge clk);
        if (ld_we) begin
            m_mem[ld_addr] = ld_word;
        end else if (ex) begin
            if (c[11]) begin
                m_mem[fa][7:0] = m_pc + 8'd1;
                m_pc    = fb;
                m_carry = 1'b0;
            end else begin
                if (c[15])      m_mem[fa][7:0] = r[7:0];
                else if (c[14]) m_mem[fb][7:0] = r[7:0];
                if (!c[12]) begin
                    case (c[7:6])
                        2'd1: m_carry = r[8];
                        2'd2: m_carry = 1'b0;
                        2'd3: m_carry = 1'b1;
                        default: ;
                    endcase
                end
                m_pc = tk ? fb : m_pc + 8'd1;
            end
            m_halted = c[12];
        end
        @(negedge clk);
        chk("R5 pc", {24'd0, pc}, {24'd0, m_pc});
        chk("R6 carry", {31'd0, carry}, {31'd0, m_carry});
        chk("R8 halted", {31'd0, halted}, {31'd0, m_halted});
    endtask

    task automatic peek_chk(string tag, logic [7:0] addr, logic [31:0] exp);
        peek_addr = addr;
        #1;
        chk(tag, peek_word, exp);
    endtask

    task automatic run_until_halt();
        for (int k = 0; k < 300 && !m_halted; k++) tick();
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] img [256];
        for (int i = 0; i < 256; i++) img[i] = {24'hC3A596, 8'(i * 7)};
        img[8'h00] = {cw(1,0,0,0,0,3'd3,2'd1,0,5'd4), 8'h40, 8'h00}; // count, jump while no carry-out
        img[8'h01] = {cw(0,1,0,0,0,3'd0,2'd1,0,5'd0), 8'h41, 8'h42}; // add into B
        img[8'h02] = {cw(0,1,1,0,0,3'd0,2'd2,1,5'd0), 8'h5A, 8'h43}; // store immediate
        img[8'h03] = {cw(1,0,0,0,0,3'd0,2'd1,0,5'd2), 8'h44, 8'h45}; // reverse subtract into A
        img[8'h04] = {cw(0,1,0,0,1,3'd0,2'd3,0,5'd0), 8'h46, 8'h10}; // call with conflicting bits
        img[8'h10] = {cw(0,0,0,0,0,3'd0,2'd3,0,5'd0), 8'h00, 8'h00}; // set carry
        img[8'h11] = {cw(0,0,0,0,0,3'd6,2'd0,0,5'd0), 8'h00, 8'h20}; // jump on carry set
        img[8'h20] = {cw(0,0,0,1,0,3'd0,2'd2,0,5'd0), 8'h00, 8'h00}; // halt, clear mode ignored
        img[8'h21] = {cw(0,0,0,0,0,3'd4,2'd1,1,5'd0), 8'h47, 8'h30}; // jump on zero result
        img[8'h30] = {cw(1,1,0,0,0,3'd0,2'd0,0,5'd0), 8'h48, 8'h49}; // both write bits
        img[8'h31] = {cw(0,0,0,0,0,3'd7,2'd0,0,5'd0), 8'h00, 8'h33}; // jump on carry clear
        img[8'h33] = {cw(0,0,0,0,0,3'd5,2'd0,1,5'd0), 8'h47, 8'h10}; // nonzero: not taken
        img[8'h34] = {cw(0,0,0,0,0,3'd1,2'd0,0,5'd0), 8'h00, 8'hFF}; // jump to last word
        img[8'hFF] = {cw(0,0,0,1,0,3'd0,2'd0,0,5'd0), 8'h00, 8'h00}; // halt, PC wraps
        img[8'h40][7:0] = 8'hFC;
        img[8'h41][7:0] = 8'h90;
        img[8'h42][7:0] = 8'h85;
        img[8'h44][7:0] = 8'h30;
        img[8'h45][7:0] = 8'h20;
        img[8'h47][7:0] = 8'h00;
        img[8'h48][7:0] = 8'h11;
        img[8'h49][7:0] = 8'h22;
        for (int i = 0; i < 256; i++) m_mem[i] = 32'd0;

        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", {24'd0, pc}, 32'd0);
        chk("R1 carry", {31'd0, carry}, 32'd0);
        chk("R1 halted", {31'd0, halted}, 32'd1);
        rst_n = 1'b1;

        // R10: load every word while halted
        for (int i = 0; i < 256; i++) begin
            ld_we = 1'b1; ld_addr = 8'(i); ld_word = img[i];
            tick();
        end
        ld_we = 1'b0;
        mem_ready = 1'b1;
        peek_chk("R11 peek", 8'h00, img[8'h00]);

        // R9: one-cycle run pulse starts execution
        run = 1'b1; tick(); run = 1'b0;
        chk("R9 running", {31'd0, halted}, 32'd0);
        tick();
        // R10: a load in mid-loop stalls the step
        ld_we = 1'b1; ld_addr = 8'h80; ld_word = 32'h1234_5678;
        tick();
        chk("R10 stall pc", {24'd0, pc}, 32'd0);
        ld_we = 1'b0;
        run_until_halt();
        chk("R8 halt pc", {24'd0, pc}, 32'h21);
        chk("R8 carry kept", {31'd0, carry}, 32'd1);

        // R8: parked unit holds while inputs idle
        repeat (5) tick();
        chk("R8 parked pc", {24'd0, pc}, 32'h21);

        // R9: a step pulse restarts execution
        step = 1'b1; tick(); step = 1'b0;
        chk("R9 step jump", {24'd0, pc}, 32'h30);
        run_until_halt();
        chk("R5 wrap", {24'd0, pc}, 32'h00);

        // Final memory images
        peek_chk("R4 loop var", 8'h40, {24'hC3A596, 8'h00});
        peek_chk("R4 addto", 8'h42, {24'hC3A596, 8'h15});
        peek_chk("R3 store", 8'h43, {24'hC3A596, 8'h5A});
        peek_chk("R4 write A", 8'h44, {24'hC3A596, 8'hF0});
        peek_chk("R7 link", 8'h46, {24'hC3A596, 8'h05});
        peek_chk("R4 both bits A", 8'h48, {24'hC3A596, 8'h33});
        peek_chk("R4 both bits B", 8'h49, {24'hC3A596, 8'h22});
        peek_chk("R10 load", 8'h80, 32'h1234_5678);
        for (int i = 0; i < 256; i++) peek_chk("R11 image", 8'(i), m_mem[i]);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule